// File: doc/BRIEF.md
# Watchdog Timer with Control Register

This block is a watchdog for an 8-bit microcontroller core. It sits on the core's special-function-register bus, which carries an address, write data, a write strobe, a read strobe and read data. A control byte sets the timeout, switches the watchdog on or off, restarts the count and selects one of two 16-bit pointer banks. The same register set holds those two pointer banks. The bank that the control byte selects drives a 16-bit pointer output. The register set also holds a power-off flag that an ordinary reset leaves alone.

An external 1 ms tick is the time base. While the watchdog runs, it counts ticks. When the count reaches the selected period, the block raises a one-cycle reset request and starts counting again from zero. Software keeps the request from happening by writing the restart bit more often than the period. A dedicated power-on reset input marks a cold start in the power-off flag.

Top module: `wdt_sfr_top`

## Requirements
- R1: After `rst` or `por`, all of the following hold:
  - the control byte at 96H reads 00H;
  - all four pointer bytes read 00H;
  - `dptr` is 0000H;
  - `wdt_reset_req` is low;
  - the watchdog is stopped.
- R2: The pointer bytes map as follows, and each one reads back the last value written to it:
  - 82H is the low byte of bank 0;
  - 83H is the high byte of bank 0;
  - 84H is the low byte of bank 1;
  - 85H is the high byte of bank 1.
- R3: `dptr` follows the bank that control bit 2 selects: 0 selects bank 0 and 1 selects bank 1. It changes in the cycle after the control write.
- R4: With control bit 0 set, each `tick_ms` pulse advances a count. The timeout is chosen as follows:
  - the prescaler is control bits 7:5;
  - the period is 16 << prescaler ticks;
  - when a tick arrives with the count at or past period-1, `wdt_reset_req` goes high for exactly the next cycle and the count returns to 0.
- R5: With control bit 0 clear, ticks are ignored, the count is held at 0 and `wdt_reset_req` stays low.
- R6: Writing the control byte with bit 1 set restarts the count. The restart takes effect in the cycle after the write, and a tick in that cycle is dropped. Bit 1 always reads 0.
- R7: The following read as 0 and do nothing:
  - control bits 4:3 ignore writes;
  - unmapped addresses;
  - any read with `sfr_rd` low.
- R8: The power-off flag is bit 4 of the power byte at 87H, and the other bits of that byte read 0. The flag is handled as follows:
  - `por` sets it;
  - software can write it;
  - `rst` leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset; does not touch the power-off flag |
| por | input | 1 | Synchronous active-high power-on reset; resets everything and sets the flag |
| tick_ms | input | 1 | One-cycle 1 ms time-base pulse |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Write data |
| sfr_wr | input | 1 | Write strobe |
| sfr_rd | input | 1 | Read strobe |
| sfr_rdata | output | 8 | Read data; combinational, and 0 when not reading |
| dptr | output | 16 | Active pointer bank |
| wdt_reset_req | output | 1 | One-cycle watchdog expiry request |

## Verification
The hidden count shows up at the ports only through `wdt_reset_req`. A count that starts wrong, advances on the wrong ticks or ignores a restart therefore moves the request pulse by one or more ticks. For a stuck or early count, the pulse appears or goes missing in the very period where the fault occurs. A wrong bank, a wrong field position or a flag that a reset clears is visible on the next read or in the next cycle of `dptr`. For that reason the bench compares the read data, the pointer and the request against its model on every cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int DW         = 8;
    localparam int AW         = 8;
    localparam int PS_W       = 3;
    localparam int BASE_TICKS = 16;
    localparam int MAX_TICKS  = BASE_TICKS << ((1 << PS_W) - 1);
    localparam int CNT_W      = $clog2(MAX_TICKS);

    localparam logic [AW-1:0] A_CTRL  = 8'h96;
    localparam logic [AW-1:0] A_PTR0  = 8'h82;
    localparam logic [AW-1:0] A_POWER = 8'h87;

    localparam int B_EN   = 0;
    localparam int B_KICK = 1;
    localparam int B_SEL  = 2;
    localparam int B_PS   = 5;
    localparam int B_POF  = 4;

    typedef struct packed {
        logic [PS_W-1:0] ps;
        logic            sel;
        logic            en;
    } ctrl_t;

    function automatic logic [CNT_W:0] period_of(input logic [PS_W-1:0] ps);
        logic [CNT_W:0] base;
        base = BASE_TICKS[CNT_W:0];
        return base << ps;
    endfunction

    function automatic logic [DW-1:0] ctrl_byte(input ctrl_t c);
        logic [DW-1:0] b;
        b = '0;
        b[B_PS +: PS_W] = c.ps;
        b[B_SEL]        = c.sel;
        b[B_EN]         = c.en;
        return b;
    endfunction
endpackage

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
    import wdg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [PS_W-1:0] ps_in,
    input  logic            sel_in,
    input  logic            kick_in,
    input  logic            en_in,
    output ctrl_t           ctrl_o,
    output logic            kick_o
);
    ctrl_t ctrl_q;
    logic  kick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            kick_q <= 1'b1;
        end else begin
            kick_q <= wr & kick_in;
            if (wr) begin
                ctrl_q.ps  <= ps_in;
                ctrl_q.sel <= sel_in;
                ctrl_q.en  <= en_in;
            end
        end
    end

    assign ctrl_o = ctrl_q;
    assign kick_o = kick_q;
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            en,
    input  logic            kick,
    input  logic [PS_W-1:0] ps,
    output logic            req_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             req_q;
    logic [CNT_W:0]   limit;

    assign limit = period_of(ps) - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            req_q <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (kick || !en) begin
                cnt_q <= '0;
            end else if (tick) begin
                if ({1'b0, cnt_q} >= limit) begin
                    cnt_q <= '0;
                    req_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign req_o = req_q;
endmodule

// File: rtl/wdg_ptr_banks.sv
module wdg_ptr_banks
    import wdg_pkg::*;
#(
    parameter int NBANKS = 2,
    localparam int PW    = 2 * DW,
    localparam int SEL_W = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [SEL_W-1:0] sel,
    output logic             hit_o,
    output logic [DW-1:0]    rbyte_o,
    output logic [PW-1:0]    ptr_o
);
    logic [PW-1:0]     bank_q [NBANKS];
    logic [NBANKS-1:0] hit_lo, hit_hi;

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        localparam logic [AW-1:0] LO = AW'(int'(A_PTR0) + 2 * b);
        localparam logic [AW-1:0] HI = AW'(int'(A_PTR0) + 2 * b + 1);
        assign hit_lo[b] = (addr == LO);
        assign hit_hi[b] = (addr == HI);
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q[b] <= '0;
            end else if (wr) begin
                if (hit_lo[b]) bank_q[b][DW-1:0]  <= wdata;
                if (hit_hi[b]) bank_q[b][PW-1:DW] <= wdata;
            end
        end
    end

    always_comb begin
        rbyte_o = '0;
        for (int b = 0; b < NBANKS; b++) begin
            if (hit_lo[b]) rbyte_o = bank_q[b][DW-1:0];
            if (hit_hi[b]) rbyte_o = bank_q[b][PW-1:DW];
        end
    end

    assign hit_o = |{hit_lo, hit_hi};
    assign ptr_o = bank_q[sel];
endmodule

// File: rtl/wdt_sfr_top.sv
module wdt_sfr_top
    import wdg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          por,
    input  logic          tick_ms,
    input  logic [AW-1:0] sfr_addr,
    input  logic [DW-1:0] sfr_wdata,
    input  logic          sfr_wr,
    input  logic          sfr_rd,
    output logic [DW-1:0] sfr_rdata,
    output logic [15:0]   dptr,
    output logic          wdt_reset_req
);
    logic          any_rst;
    logic          wr_ctrl, wr_pow;
    ctrl_t         ctrl;
    logic          kick;
    logic          ptr_hit;
    logic [DW-1:0] ptr_byte;
    logic          pof_q;

    assign any_rst = rst | por;
    assign wr_ctrl = sfr_wr && (sfr_addr == A_CTRL);
    assign wr_pow  = sfr_wr && (sfr_addr == A_POWER);

    wdg_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (any_rst),
        .wr      (wr_ctrl),
        .ps_in   (sfr_wdata[B_PS +: PS_W]),
        .sel_in  (sfr_wdata[B_SEL]),
        .kick_in (sfr_wdata[B_KICK]),
        .en_in   (sfr_wdata[B_EN]),
        .ctrl_o  (ctrl),
        .kick_o  (kick)
    );

    wdg_timer u_timer (
        .clk   (clk),
        .rst   (any_rst),
        .tick  (tick_ms),
        .en    (ctrl.en),
        .kick  (kick),
        .ps    (ctrl.ps),
        .req_o (wdt_reset_req)
    );

    wdg_ptr_banks #(.NBANKS(2)) u_ptr (
        .clk     (clk),
        .rst     (any_rst),
        .wr      (sfr_wr),
        .addr    (sfr_addr),
        .wdata   (sfr_wdata),
        .sel     (ctrl.sel),
        .hit_o   (ptr_hit),
        .rbyte_o (ptr_byte),
        .ptr_o   (dptr)
    );

    always_ff @(posedge clk) begin
        if (por)         pof_q <= 1'b1;
        else if (rst)    pof_q <= pof_q;
        else if (wr_pow) pof_q <= sfr_wdata[B_POF];
    end

    always_comb begin
        sfr_rdata = '0;
        if (sfr_rd) begin
            if (sfr_addr == A_CTRL)       sfr_rdata = ctrl_byte(ctrl);
            else if (sfr_addr == A_POWER) sfr_rdata[B_POF] = pof_q;
            else if (ptr_hit)             sfr_rdata = ptr_byte;
        end
    end
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk (
    input logic        clk,
    input logic        rst,
    input logic        por,
    input logic        en,
    input logic        kick,
    input logic        req,
    input logic        pof,
    input logic [15:0] dptr
);
    assert_reset_state_R1: assert property (@(posedge clk)
        (rst || por) |=> (!en && !req && kick && dptr == 16'h0000));

    assert_req_single_R4: assert property (@(posedge clk) disable iff (rst || por)
        req |=> !req);

    assert_off_quiet_R5: assert property (@(posedge clk) disable iff (rst || por)
        !en |=> !req);

    assert_kick_noreq_R6: assert property (@(posedge clk) disable iff (rst || por)
        kick |=> !req);

    assert_flag_kept_R8: assert property (@(posedge clk) disable iff (por)
        rst |=> (pof == $past(pof)));
endmodule

bind wdt_sfr_top wdg_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .por  (por),
    .en   (ctrl.en),
    .kick (kick),
    .req  (wdt_reset_req),
    .pof  (pof_q),
    .dptr (dptr)
);

// File: tb/wdt_sfr_top_tb.sv
`timescale 1ns/1ps
module wdt_sfr_top_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       por = 1'b1;
    logic       tick_ms = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic [7:0] sfr_wdata = 8'h00;
    logic       sfr_wr = 1'b0;
    logic       sfr_rd = 1'b0;
    logic [7:0] sfr_rdata;
    logic [15:0] dptr;
    logic       wdt_reset_req;

    always #5 clk = ~clk;

    wdt_sfr_top u_dut (
        .clk(clk), .rst(rst), .por(por), .tick_ms(tick_ms),
        .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_wr(sfr_wr),
        .sfr_rd(sfr_rd), .sfr_rdata(sfr_rdata), .dptr(dptr),
        .wdt_reset_req(wdt_reset_req)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    req_seen = 0;
    string tag = "R1";
    bit    done = 0;

    int   m_ps = 0, m_cnt = 0;
    bit   m_sel = 0, m_en = 0, m_kick = 1, m_req = 0, m_pof = 1;
    int   m_lo [2] = '{0, 0};
    int   m_hi [2] = '{0, 0};

    always @(posedge clk) begin
        if (por || rst) begin
            m_ps = 0; m_sel = 0; m_en = 0; m_kick = 1; m_cnt = 0; m_req = 0;
            m_lo = '{0, 0}; m_hi = '{0, 0};
            if (por) m_pof = 1;
        end else begin
            bit nreq;
            nreq = 0;
            if (m_kick || !m_en) m_cnt = 0;
            else if (tick_ms) begin
                if (m_cnt >= (16 << m_ps) - 1) begin m_cnt = 0; nreq = 1; end
                else m_cnt = m_cnt + 1;
            end
            m_req = nreq;
            m_kick = sfr_wr && sfr_addr == 8'h96 && sfr_wdata[1];
            if (sfr_wr) begin
                case (sfr_addr)
                    8'h96: begin m_ps = int'(sfr_wdata[7:5]); m_sel = sfr_wdata[2]; m_en = sfr_wdata[0]; end
                    8'h82: m_lo[0] = int'(sfr_wdata);
                    8'h83: m_hi[0] = int'(sfr_wdata);
                    8'h84: m_lo[1] = int'(sfr_wdata);
                    8'h85: m_hi[1] = int'(sfr_wdata);
                    8'h87: m_pof = sfr_wdata[4];
                    default: ;
                endcase
            end
        end
    end

    function automatic int exp_rdata();
        if (!sfr_rd) return 0;
        case (sfr_addr)
            8'h96: return (m_ps << 5) | (int'(m_sel) << 2) | int'(m_en);
            8'h87: return int'(m_pof) << 4;
            8'h82: return m_lo[0];
            8'h83: return m_hi[0];
            8'h84: return m_lo[1];
            8'h85: return m_hi[1];
            default: return 0;
        endcase
    endfunction

    task automatic check(input string t, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", t, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!por && !rst && !done) begin
            check({tag, " rdata"}, int'(sfr_rdata), exp_rdata());
            check({tag, " dptr"}, int'(dptr), m_sel ? (m_hi[1] << 8 | m_lo[1]) : (m_hi[0] << 8 | m_lo[0]));
            check({tag, " req"}, int'(wdt_reset_req), int'(m_req));
            if (wdt_reset_req) req_seen++;
        end
    end

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1; sfr_rd = 1'b0;
        cyc();
        sfr_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        sfr_addr = a; sfr_rd = 1'b1;
        cyc();
        sfr_rd = 1'b0;
    endtask

    task automatic run_ticks(input int cycles, input int every);
        for (int i = 0; i < cycles; i++) begin
            tick_ms = (i % every) == 0;
            cyc();
        end
        tick_ms = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        cyc(3);
        por = 1'b0;
        tag = "R1";
        rd(8'h96); rd(8'h82); rd(8'h85); cyc(2);
        tag = "R8";
        rd(8'h87); wr(8'h87, 8'hEF); rd(8'h87);
        rst = 1'b1; cyc(2); rst = 1'b0; rd(8'h87);
        wr(8'h87, 8'h10); rd(8'h87);
        wr(8'h87, 8'h00); por = 1'b1; cyc(); por = 1'b0; rd(8'h87);
        tag = "R2";
        wr(8'h82, 8'h11); wr(8'h83, 8'h22); wr(8'h84, 8'h33); wr(8'h85, 8'h44);
        rd(8'h82); rd(8'h83); rd(8'h84); rd(8'h85);
        tag = "R3";
        wr(8'h96, 8'h04); cyc(2); wr(8'h96, 8'h00); cyc(2);
        wr(8'h96, 8'h04); wr(8'h85, 8'hA5); cyc();
        tag = "R7";
        wr(8'h96, 8'h18); rd(8'h96); rd(8'h90); rd(8'h00);
        sfr_addr = 8'h84; cyc(2);
        tag = "R1";
        rst = 1'b1; cyc(); rst = 1'b0; rd(8'h96); rd(8'h84); cyc();
        tag = "R4";
        req_seen = 0;
        wr(8'h96, 8'h01); run_ticks(40, 1);
        check("R4 pulses ps0", req_seen, 2);
        req_seen = 0;
        wr(8'h96, 8'h61); run_ticks(300, 2);
        check("R4 pulses ps3", req_seen, 1);
        req_seen = 0;
        wr(8'h96, 8'hE1); run_ticks(2100, 1);
        check("R4 pulses ps7", req_seen, 1);
        wr(8'h96, 8'h61); run_ticks(100, 1);
        wr(8'h96, 8'h01); run_ticks(20, 1);
        tag = "R5";
        req_seen = 0;
        wr(8'h96, 8'h00); run_ticks(100, 1);
        check("R5 no pulse disabled", req_seen, 0);
        tag = "R6";
        req_seen = 0;
        wr(8'h96, 8'h01);
        for (int k = 0; k < 20; k++) begin
            run_ticks(10, 1);
            tick_ms = 1'b1; wr(8'h96, 8'h03); tick_ms = 1'b1;
            sfr_addr = 8'h96; sfr_rd = 1'b1; cyc(); sfr_rd = 1'b0; tick_ms = 1'b0;
        end
        check("R6 kicked no pulse", req_seen, 0);
        run_ticks(40, 1);
        cyc(3);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule